// File: doc/BRIEF.md
# Scanline Interrupt Counter with Address-Line Filter

This block watches one bit of the graphics chip's address bus, address line 12, which rises once per drawn line as the fetcher moves from the low pattern half to the high one. Each qualified rise steps a down-counter. When the counter reaches zero with the interrupt enabled, the block raises a level interrupt to the CPU. That interrupt stays high until software acknowledges it.

Sprite fetches toggle the line several times in quick succession. To reject those, a rise counts only after the line has been low for a programmed number of consecutive CPU clocks (three by default). Software programs a reload value, asks for a reload, and enables or acknowledges the interrupt through four write-only registers. The registers are decoded from the CPU address bits 15..13 and bit 0.

Top module: `scanline_irq_unit`

## Requirements
- R1: A rise of the watched address line (`ppu_addr[12]`) is a valid edge only if the line was sampled low on at least LOW_CYCLES (3) consecutive clocks just before it. A rise after a shorter low run leaves the counter unchanged.
- R2: A write with `cpu_addr[15:13]=3'b110` and `cpu_addr[0]=0` stores `cpu_wdata[7:0]` as the reload value.
- R3: A write with `cpu_addr[15:13]=3'b110` and `cpu_addr[0]=1` marks a reload as pending. The pending flag is consumed by the next valid edge.
- R4: On a valid edge, the counter loads the reload value and clears the pending flag if the counter is 0 or a reload is pending. Otherwise the counter decrements by one.
- R5: When the counter is 0 after a valid edge's update and the interrupt is enabled, `irq_out` goes high within three clocks of the line being sampled high. It then stays high until acknowledged.
- R6: A write with `cpu_addr[15:13]=3'b111` and `cpu_addr[0]=0` disables the interrupt and drops `irq_out` on the next clock.
- R7: A write with `cpu_addr[15:13]=3'b111` and `cpu_addr[0]=1` enables the interrupt.
- R8: Only `cpu_addr` bits 15..13 and 0 take part in the decode. Bits 12..1 are ignored, and writes with bits 15..13 below 3'b110 have no effect.
- R9: Synchronous reset clears the counter, the reload value, the pending and enable flags and `irq_out`. After reset, no edge is valid until a fresh low run of LOW_CYCLES clocks has been seen.
- R10: With a reload value of 1 and a reload pending, the first valid edge leaves `irq_out` low and the second valid edge raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Snooped graphics address bus |
| irq_out | output | 1 | Level interrupt request, registered |

## Verification
On every cycle, the assertions check the following:
- a qualified edge is a single-cycle pulse that follows a low run;
- the counter moves only on such an edge, either by a load or by a decrement of one;
- the interrupt never stands while disabled, and it holds until acknowledged;
- the register decode never fires two strobes at once.

Only the bench's scenarios can show the end-to-end edge counts that lead to an interrupt. They also show the rejection of short low runs between otherwise valid edges, the effect of mirrored and out-of-range register addresses, and the two-edge sequence after a reload of one.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  // Register selected by {cpu_addr[15:13], cpu_addr[0]}
  localparam logic [2:0] REGION_RELOAD = 3'b110;
  localparam logic [2:0] REGION_IRQ    = 3'b111;

  typedef struct packed {
    logic set_latch;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } wr_strobe_t;

  localparam wr_strobe_t WR_NONE = '{default: 1'b0};

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import scanirq_pkg::*;
#(
  parameter int CPU_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [CPU_AW-1:0] addr_i,
  output wr_strobe_t        strobe_o
);

  localparam int TOP_LO = CPU_AW - 3;

  logic [2:0] region;
  logic       odd_sel;

  assign region  = addr_i[CPU_AW-1:TOP_LO];
  assign odd_sel = addr_i[0];

  always_comb begin
    strobe_o = WR_NONE;
    if (we_i) begin
      unique case (region)
        REGION_RELOAD: begin
          strobe_o.set_latch  = !odd_sel;
          strobe_o.req_reload = odd_sel;
        end
        REGION_IRQ: begin
          strobe_o.irq_off = !odd_sel;
          strobe_o.irq_on  = odd_sel;
        end
        default: strobe_o = WR_NONE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_o.set_latch, strobe_o.req_reload, strobe_o.irq_off, strobe_o.irq_on})); // R8

endmodule

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int PPU_AW     = 14,
  parameter int LINE_IDX   = 12,
  parameter int LOW_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PPU_AW-1:0] ppu_addr_i,
  output logic              edge_o
);

  localparam int LCW = (LOW_CYCLES < 1) ? 1 : $clog2(LOW_CYCLES + 1);

  logic           line_q;
  logic [LCW-1:0] low_run_q;
  logic           qualified;

  // Input sample stage; reset value high so reset gives no low credit
  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= ppu_addr_i[LINE_IDX];
  end

  generate
    if (LOW_CYCLES == 0) begin : g_nofilter
      assign low_run_q = '0;
      assign qualified = 1'b1;
    end else begin : g_filter
      always_ff @(posedge clk) begin
        if (rst)
          low_run_q <= '0;
        else if (line_q)
          low_run_q <= '0;
        else if (low_run_q != LCW'(LOW_CYCLES))
          low_run_q <= low_run_q + 1'b1;
      end
      assign qualified = (low_run_q == LCW'(LOW_CYCLES));
    end
  endgenerate

  // A rise seen on the sample stage: the prior sample was low (run > 0)
  always_ff @(posedge clk) begin
    if (rst) edge_o <= 1'b0;
    else     edge_o <= line_q && qualified && (LOW_CYCLES == 0 ? !edge_o : 1'b1);
  end

  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o); // R1

  generate
    if (LOW_CYCLES >= 3) begin : g_chk
      AST_EDGE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> (!$past(line_q, 2) && !$past(line_q, 3) && !$past(line_q, 4))); // R1
    end
  endgenerate

endmodule

// File: rtl/scan_count_core.sv
module scan_count_core
  import scanirq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_strobe_t    strobe_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          edge_i,
  output logic          irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] latch_q;
  logic             reload_q, reload_d;
  logic             en_q;
  logic             irq_q, irq_d;
  logic             hit;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    if (edge_i) begin
      if (cnt_q == '0 || reload_q) begin
        cnt_d    = latch_q;
        reload_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (strobe_i.req_reload) reload_d = 1'b1;
    hit = edge_i && (cnt_d == '0) && en_q;
    if (strobe_i.irq_off)  irq_d = 1'b0;
    else if (hit)          irq_d = 1'b1;
    else                   irq_d = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      latch_q  <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      irq_q    <= irq_d;
      if (strobe_i.set_latch) latch_q <= wdata_i[CNT_W-1:0];
      if (strobe_i.irq_off)      en_q <= 1'b0;
      else if (strobe_i.irq_on)  en_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (edge_i && (cnt_q == '0 || reload_q)) |=> (cnt_q == $past(latch_q))); // R4
  AST_DEC_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (edge_i && cnt_q != '0 && !reload_q) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !edge_i |=> $stable(cnt_q)); // R1
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> en_q); // R6
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
    strobe_i.irq_off |=> !irq_q); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !strobe_i.irq_off) |=> irq_q); // R5

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scanirq_pkg::*;
#(
  parameter int CPU_AW     = 16,
  parameter int DW         = 8,
  parameter int PPU_AW     = 14,
  parameter int LINE_IDX   = 12,
  parameter int LOW_CYCLES = 3,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic              irq_out
);

  wr_strobe_t strobe;
  logic       line_edge;

  irq_reg_decode #(.CPU_AW(CPU_AW)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .we_i     (cpu_we),
    .addr_i   (cpu_addr),
    .strobe_o (strobe)
  );

  a12_edge_filter #(
    .PPU_AW     (PPU_AW),
    .LINE_IDX   (LINE_IDX),
    .LOW_CYCLES (LOW_CYCLES)
  ) u_filter (
    .clk        (clk),
    .rst        (rst),
    .ppu_addr_i (ppu_addr),
    .edge_o     (line_edge)
  );

  scan_count_core #(.DW(DW), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe),
    .wdata_i  (cpu_wdata),
    .edge_i   (line_edge),
    .irq_o    (irq_out)
  );

  AST_IRQ_RESET: assert property (@(posedge clk) rst |=> !irq_out); // R9

endmodule

// File: tb/scanline_irq_unit_tb.sv
module scanline_irq_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = 14'h1000;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference state, from the requirements
  int unsigned m_cnt, m_latch;
  bit m_reload, m_en, m_irq;

  always #2 clk = ~clk; // 250 MHz

  scanline_irq_unit u_dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .irq_out(irq_out)
  );

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic void model_write(logic [15:0] a, logic [7:0] d);
    if (a[15:13] == 3'b110 && !a[0]) m_latch = d;           // R2
    else if (a[15:13] == 3'b110 && a[0]) m_reload = 1'b1;   // R3
    else if (a[15:13] == 3'b111 && !a[0]) begin m_en = 0; m_irq = 0; end // R6
    else if (a[15:13] == 3'b111 && a[0]) m_en = 1'b1;       // R7
  endfunction

  function automatic void model_edge(int low_len);
    if (low_len < 3) return;                                 // R1
    if (m_cnt == 0 || m_reload) begin m_cnt = m_latch; m_reload = 0; end
    else m_cnt = m_cnt - 1;                                  // R4
    if (m_cnt == 0 && m_en) m_irq = 1'b1;                    // R5
  endfunction

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, string req);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    model_write(a, d);
    @(negedge clk);
    check(req, irq_out, m_irq);
  endtask

  task automatic line_pulse(int low_len, string req);
    @(negedge clk);
    ppu_addr = 14'($urandom) & ~14'h1000;
    repeat (low_len) @(negedge clk);
    ppu_addr = 14'($urandom) | 14'h1000;
    repeat (4) @(negedge clk);
    model_edge(low_len);
    check(req, irq_out, m_irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A12));
    m_cnt = 0; m_latch = 0; m_reload = 0; m_en = 0; m_irq = 0;
    repeat (4) @(negedge clk);
    check("R9 reset", irq_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", irq_out, 1'b0);

    // R9: enable with latch 0; a short low run after reset must not count
    cpu_write(16'hE001, 8'h00, "R7 enable");
    line_pulse(2, "R9 short run after reset");
    check("R9 r9_no_edge", irq_out, 1'b0);

    // R10: latch=1, reload, first edge quiet, second raises
    cpu_write(16'hC000, 8'h01, "R2 latch");
    cpu_write(16'hC001, 8'h00, "R3 reload");
    line_pulse(3, "R10 first edge quiet");
    line_pulse(3, "R10 second edge raises");
    check("R10 raised", irq_out, 1'b1);

    // R8: ignored regions must leave the standing interrupt alone
    cpu_write(16'h8000, 8'hFF, "R8 ignored 8000");
    cpu_write(16'hA000, 8'hFF, "R8 ignored A000");
    cpu_write(16'h6001, 8'hFF, "R8 ignored 6001");
    line_pulse(5, "R5 sticky");
    cpu_write(16'hFFFE, 8'h00, "R6 ack via mirror FFFE");
    check("R6 acked", irq_out, 1'b0);

    // R1/R4: latch 2; short runs between valid edges do not step the counter
    cpu_write(16'hE001, 8'h00, "R7 re-enable");
    cpu_write(16'hDF3E, 8'h02, "R8 R2 latch via mirror");
    cpu_write(16'hC7A1, 8'h00, "R8 R3 reload via mirror");
    line_pulse(4, "R4 load 2");
    line_pulse(1, "R1 run of 1");
    line_pulse(2, "R1 run of 2");
    line_pulse(3, "R4 decrement to 1");
    check("R1 no early irq", irq_out, 1'b0);
    line_pulse(2, "R1 run of 2 again");
    check("R1 short ignored", irq_out, 1'b0);
    line_pulse(3, "R5 decrement to 0");
    check("R5 raised", irq_out, 1'b1);

    // R6: disabled interrupt never raises
    cpu_write(16'hE000, 8'h00, "R6 disable");
    cpu_write(16'hC000, 8'h00, "R2 latch 0");
    line_pulse(3, "R6 no irq when disabled");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int kind = int'($urandom_range(0, 9));
      if (kind < 5) begin
        line_pulse(int'($urandom_range(1, 5)), "R1 R4 R5 random edge");
      end else begin
        logic [15:0] a;
        logic [7:0]  d;
        a = 16'($urandom);
        a[15:13] = 3'($urandom_range(4, 7));
        d = 8'($urandom_range(0, 3));
        cpu_write(a, d, "R2 R3 R6 R7 R8 random write");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule